// File: doc/BRIEF.md
# Clear-on-Read Statistics Counter

This block is a 16-bit read-only statistics word for a network controller. The upper ten bits count events. The lower six bits carry a fixed identifier, set by a parameter, so that software can tell which counter a word came from. The block can be built in one of two ways. In level mode it counts receive frames that were dropped for lack of buffer space, one per cycle of the increment strobe. In rising-edge mode it counts collisions: one per rising edge of collision activity while a transmit is in progress.

Each host read returns the current word and clears the count. An increment that arrives in the same cycle as the read is not lost: the count restarts at one. When the count steps from 0x1FF to 0x200 and the interrupt enable is set, an interrupt request is raised and held. This gives software an early warning, with 512 counts left before the field wraps from 0x3FF to zero. The request stays asserted until the next read.

Top module: `stat_cor_counter`

## Requirements
- R1: After reset, `rdata_o` equals the identifier in bits 5:0 with zero above it (0x0010 for identifier 0x10, 0x0012 for identifier 0x12), and `irq_o` is 0.
- R2: Bits 5:0 of `rdata_o` always equal the `ID_VALUE` parameter.
- R3: Each qualified increment raises the count in bits 15:6 by one, visible on `rdata_o` in the cycle after the increment cycle. With no increment and no read, the count holds.
- R4: An increment at count 0x3FF wraps the count to 0x000.
- R5: During a cycle with `rd_i` high, `rdata_o` shows the count before clearing. In the next cycle the count is 0 if no increment coincided.
- R6: A read that coincides with a qualified increment leaves the count at 1.
- R7: An increment that takes the count from 0x1FF to 0x200 while `irq_en_i` is 1 sets `irq_o` in the next cycle. The same step with `irq_en_i` at 0 leaves `irq_o` low.
- R8: Once set, `irq_o` stays high until a read. It is 0 in the cycle after `rd_i` is high.
- R9: In rising-edge mode, a qualified increment is a cycle in which `evt_i` is 1, `evt_i` was 0 in the previous cycle, and `xmit_i` is 1. Holding `evt_i` high counts once. An edge while `xmit_i` is 0 is not counted.
- R10: In level mode, every cycle with `evt_i` high is one increment, whatever the value of `xmit_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Event strobe (level mode) or collision activity (rising-edge mode) |
| xmit_i | input | 1 | Transmit in progress; qualifies edges in rising-edge mode |
| rd_i | input | 1 | Host read strobe; clears the count and the interrupt |
| irq_en_i | input | 1 | Enables the half-range interrupt |
| rdata_o | output | 16 | Count in bits 15:6, identifier in bits 5:0 |
| irq_o | output | 1 | Latched half-range interrupt request |

## Verification
The bench aims at the cases below. Each one is listed with how a faulty design would show it.
- The exact step from 0x1FF to 0x200, tried with the enable on and then off. A comparator off by one, or one that ignores the enable, raises the request a count early, a count late, or when it should stay quiet.
- A read that coincides with an increment. A design that clears too eagerly reads back zero instead of one.
- The wrap from 0x3FF, which an unmasked adder would carry into the identifier bits.
- In rising-edge mode, collision activity held over many cycles and edges outside a transmit. A level-sensitive or ungated counter overcounts in both cases.

// File: rtl/stat_pkg.sv
package stat_pkg;

    // How the raw event input is turned into count increments.
    typedef enum logic {
        CNT_LEVEL = 1'b0,   // every active cycle counts
        CNT_RISE  = 1'b1    // rising edge, gated by transmit activity
    } cnt_mode_e;

    // Value at which the half-range warning fires, for a given count width.
    function automatic int unsigned half_range(input int unsigned width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/stat_evt_qual.sv
module stat_evt_qual
    import stat_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic gate_i,
    output logic inc_o
);

    typedef struct packed {
        logic prev;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     edge_ok;
    logic     gate_ok;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (MODE == CNT_RISE) begin : g_rise
            assign edge_ok = ~st_q.prev;
            assign gate_ok = gate_i;
        end else begin : g_level
            // Level mode: the history and the gate play no part.
            assign edge_ok = 1'b1 | st_q.prev;
            assign gate_ok = 1'b1 | gate_i;
        end
    endgenerate

    assign inc_o = evt_i & edge_ok & gate_ok;

endmodule

// File: rtl/stat_cnt_core.sv
module stat_cnt_core
    import stat_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cross_o
);

    localparam logic [CNT_W-1:0] MID_M1 = CNT_W'(half_range(CNT_W) - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cross_o = 1'b0;
        if (clr_i) begin
            // A clearing read keeps any coincident event.
            st_d.cnt = inc_i ? ONE : '0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + ONE;   // wraps naturally at full range
            cross_o  = (st_q.cnt == MID_M1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/stat_irq_latch.sv
module stat_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic en_i,
    input  logic clr_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.irq = 1'b0;
        end else if (set_i && en_i) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/stat_cor_counter.sv
module stat_cor_counter
    import stat_pkg::*;
#(
    parameter int unsigned    CNT_W    = 10,
    parameter int unsigned    ID_W     = 6,
    parameter logic [ID_W-1:0] ID_VALUE = 6'h10,
    parameter cnt_mode_e      MODE     = CNT_LEVEL,
    localparam int unsigned   DW       = CNT_W + ID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          xmit_i,
    input  logic          rd_i,
    input  logic          irq_en_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);

    logic             inc_w;
    logic             cross_w;
    logic [CNT_W-1:0] cnt_w;

    stat_evt_qual #(.MODE(MODE)) i_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .gate_i (xmit_i),
        .inc_o  (inc_w)
    );

    stat_cnt_core #(.CNT_W(CNT_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc_w),
        .clr_i   (rd_i),
        .cnt_o   (cnt_w),
        .cross_o (cross_w)
    );

    stat_irq_latch i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cross_w),
        .en_i  (irq_en_i),
        .clr_i (rd_i),
        .irq_o (irq_o)
    );

    assign rdata_o = {cnt_w, ID_VALUE};

endmodule

// File: rtl/stat_cor_counter_chk.sv
module stat_cor_counter_chk #(
    parameter int unsigned     CNT_W    = 10,
    parameter int unsigned     ID_W     = 6,
    parameter logic [ID_W-1:0] ID_VALUE = 6'h10,
    parameter bit              RISE     = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_i,
    input logic             xmit_i,
    input logic             rd_i,
    input logic             irq_en_i,
    input logic             inc,
    input logic [CNT_W-1:0] count,
    input logic [ID_W-1:0]  id_bits,
    input logic             irq
);

    localparam logic [CNT_W-1:0] MID_M1 = CNT_W'((32'd1 << (CNT_W - 1)) - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    // R2
    a_r2_id_field: assert property (@(posedge clk) disable iff (!rst_n)
        id_bits == ID_VALUE);

    // R3
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && inc) |=> count == CNT_W'($past(count) + ONE));

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !inc) |=> $stable(count));

    // R5
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !inc) |=> count == '0);

    // R6
    a_r6_read_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && inc) |=> count == ONE);

    // R7
    a_r7_half_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && inc && irq_en_i && count == MID_M1) |=> irq);

    // R7
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !irq_en_i && !irq) |=> !irq);

    // R8
    a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_i) |=> irq);

    // R8
    a_r8_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> !irq);

    // R9
    a_r9_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (RISE && inc) |-> (evt_i && xmit_i));

    // R10
    a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!RISE) |-> (inc == evt_i));

endmodule

bind stat_cor_counter stat_cor_counter_chk #(
    .CNT_W    (CNT_W),
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE),
    .RISE     (MODE == stat_pkg::CNT_RISE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .xmit_i   (xmit_i),
    .rd_i     (rd_i),
    .irq_en_i (irq_en_i),
    .inc      (inc_w),
    .count    (cnt_w),
    .id_bits  (rdata_o[ID_W-1:0]),
    .irq      (irq_o)
);

// File: tb/test_stat_cor_counter.sv
module test_stat_cor_counter;
    import stat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 1'b0, xmit = 1'b0, rd = 1'b0, en = 1'b0;
    logic [15:0] rdata_l, rdata_c;
    logic        irq_l, irq_c;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done  = 1'b0;
    string       ph_tag = "R3";

    // Reference state for both instances (index 0: level, 1: rising edge).
    logic [9:0] m_cnt [2];
    logic       m_irq [2];
    logic       m_prev;

    always #10 clk = ~clk;   // 50 MHz

    stat_cor_counter #(.ID_VALUE(6'h10), .MODE(CNT_LEVEL)) i_stat_cor_counter (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .xmit_i(xmit), .rd_i(rd),
        .irq_en_i(en), .rdata_o(rdata_l), .irq_o(irq_l));

    stat_cor_counter #(.ID_VALUE(6'h12), .MODE(CNT_RISE)) i_stat_cor_counter_col (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .xmit_i(xmit), .rd_i(rd),
        .irq_en_i(en), .rdata_o(rdata_c), .irq_o(irq_c));

    function automatic logic [15:0] word(input logic [9:0] c, input logic [5:0] id);
        return {c, id};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input int idx, input logic inc, input logic r, input logic e);
        if (r) begin
            m_cnt[idx] = inc ? 10'd1 : 10'd0;
            m_irq[idx] = 1'b0;
        end else if (inc) begin
            if (m_cnt[idx] == 10'h1FF && e) m_irq[idx] = 1'b1;
            m_cnt[idx] = m_cnt[idx] + 10'd1;
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " level word"}, 32'(rdata_l), 32'(word(m_cnt[0], 6'h10)));
        chk({tag, " level irq"},  32'(irq_l),   32'(m_irq[0]));
        chk({tag, " edge word"},  32'(rdata_c), 32'(word(m_cnt[1], 6'h12)));
        chk({tag, " edge irq"},   32'(irq_c),   32'(m_irq[1]));
    endtask

    // Compare the present state, then drive one cycle of inputs and advance the model.
    task automatic step(input logic e_v, input logic x_v, input logic r_v, input logic en_v);
        logic inc_c;
        @(negedge clk);
        compare_all(ph_tag);
        evt = e_v; xmit = x_v; rd = r_v; en = en_v;
        inc_c  = e_v & x_v & ~m_prev;
        m_prev = e_v;
        model(0, e_v, r_v, en_v);
        model(1, inc_c, r_v, en_v);
    endtask

    // Sample just after the edge that applied the last step.
    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt[0] = '0; m_cnt[1] = '0; m_irq[0] = 0; m_irq[1] = 0; m_prev = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        chk("R1 level reset word", 32'(rdata_l), 32'h0010);
        chk("R1 edge reset word",  32'(rdata_c), 32'h0012);
        chk("R1 irq reset", 32'({irq_l, irq_c}), 32'h0);
        rst_n = 1'b1;

        // R10 and R9: level counts each cycle, edge counts once for a held input.
        ph_tag = "R10";
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0);
        step(0, 0, 0, 0);
        settle();
        chk("R10 level five cycles", 32'(rdata_l[15:6]), 32'd5);
        chk("R9 held activity counts once", 32'(rdata_c[15:6]), 32'd1);

        // R9: edges outside transmit are ignored; R10: level ignores xmit.
        ph_tag = "R9";
        for (int i = 0; i < 6; i++) step(i % 2 == 0, 0, 0, 0);
        step(0, 0, 0, 0);
        settle();
        chk("R9 no count without transmit", 32'(rdata_c[15:6]), 32'd1);
        chk("R10 level ignores xmit", 32'(rdata_l[15:6]), 32'd8);
        chk("R2 identifiers", 32'({rdata_l[5:0], rdata_c[5:0]}), 32'h0412);

        // R5: read shows value then clears.
        ph_tag = "R5";
        step(0, 0, 1, 0);
        chk("R5 value during read", 32'(rdata_l), 32'(word(10'd8, 6'h10)));
        step(0, 0, 0, 0);
        chk("R5 cleared after read", 32'(rdata_l), 32'h0010);

        // R7: cross 0x1FF -> 0x200 with enable.
        ph_tag = "R7";
        for (int i = 0; i < 511; i++) step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        settle();
        chk("R7 at 0x1FF no irq", 32'({rdata_l[15:6], irq_l}), 32'({10'h1FF, 1'b0}));
        step(1, 0, 0, 1);
        settle();
        chk("R7 irq after crossing", 32'({rdata_l[15:6], irq_l}), 32'({10'h200, 1'b1}));

        // R8: held while idle with enable low, cleared by read.
        ph_tag = "R8";
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0);
        settle();
        chk("R8 irq held", 32'(irq_l), 32'd1);
        step(0, 0, 1, 0);
        settle();
        chk("R8 irq cleared by read", 32'(irq_l), 32'd0);

        // R6: read coinciding with increment.
        ph_tag = "R6";
        step(1, 0, 1, 0);
        settle();
        chk("R6 read with event leaves one", 32'(rdata_l[15:6]), 32'd1);

        // R7 masked crossing, then R4 wrap.
        ph_tag = "R4";
        for (int i = 0; i < 1022; i++) step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        settle();
        chk("R7 masked crossing no irq", 32'(irq_l), 32'd0);
        chk("R4 at top", 32'(rdata_l[15:6]), 32'h3FF);
        step(1, 0, 0, 0);
        settle();
        chk("R4 wrap to zero", 32'(rdata_l), 32'h0010);

        // R3: random traffic against the model.
        ph_tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 97) == 0,
                 ($urandom % 2) == 1);
        end
        step(0, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule